// File: doc/BRIEF.md
# I2C Target with Software-Held Clock

An I2C bus target that receives and sends bytes for a host processor. Both bus lines are open-drain: the block reads each line and drives it only by pulling it low through an enable output. A small register port lets the host set a control word and the target's own address, and read the last received byte. A byte output, a byte input, a receive-full flag, a direction flag and an interrupt pulse connect it to the host's data path.

The target answers 7-bit addresses and 10-bit addresses. It can also answer the all-zero general call, or answer every address at all. It holds the clock line low to pace the bus through a release bit in the control word. Hardware clears this bit before each byte it must send, and optionally after each byte it has received. The host sets the bit again once it has loaded the next byte or taken the last one.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: While control bit 0 (on) is 0, the block never pulls SDA or SCL low, acknowledges nothing and raises no interrupt.
- R2: With control bit 1 (wide) at 0, a first byte whose bits 7:1 equal address bits 6:0 is acknowledged by pulling SDA low through the ninth clock; bit 0 of that byte is the direction (1 = target sends). Any other byte gets no acknowledge.
- R3: With wide at 1, a write header 11110, addr[9:8], 0 followed by a byte equal to addr[7:0] is acknowledged twice, with one interrupt after the second byte. A later repeated START with header 11110, addr[9:8], 1 enters sending. A wrong second byte is not acknowledged.
- R4: With control bit 2 (take-all) at 1, every address byte is acknowledged, whatever the stored address.
- R5: With take-all at 0, the write address 0x00 is acknowledged with an interrupt only when control bit 3 (general call) is 1.
- R6: Each received data byte is acknowledged, appears on rx_data, sets rx_full and gives one single-cycle irq pulse. A register read with select 2 returns the byte and clears rx_full.
- R7: While sending, the byte is shifted out MSB first and rw_flag is 1. A master ACK continues with the next byte. A master NACK ends the transfer. Each sent byte gives one irq pulse.
- R8: After reset the control word (select 0) reads 0x0020: only bit 5, the SCL release bit, is 1. The address (select 1) reads 0.
- R9: With control bit 4 (hold enable) at 1, the host may write bit 5 to 0 or 1. While bit 5 is 0, SCL is held low from its next low phase onward. Writing 1 lets SCL go high.
- R10: With hold enable at 0, a write of 0 to bit 5 is ignored (it reads back 1), and received bytes never stretch the clock.
- R11: Hardware clears bit 5 when a send begins (after the read address ACK and after each master ACK), so SCL is held before the byte is shifted out. With hold enable at 1, it also clears bit 5 after each received data byte's ACK.
- R12: The block changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low |
| scl_oe | output | 1 | Pull SCL low (stretch) |
| reg_we | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (select 2 clears rx_full) |
| reg_sel | input | 2 | 0 control, 1 address, 2 received byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_sel |
| tx_data | input | 8 | Byte to send, taken while the clock is held |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Received byte not yet read |
| rw_flag | output | 1 | 1 when the last matched address asked the target to send |
| irq | output | 1 | One-cycle pulse per address match and per data byte |

## Verification
The embedded properties watch several rules on every cycle. A disabled block drives neither line. The interrupt never lasts two cycles. The direction flag is set throughout a send. A send always starts with the release bit cleared. The clock is pulled only after the release bit was low. SDA moves only in the low clock phase. Without hold enable, the release bit can fall only at a send start. Address decoding in both widths, the general-call and take-all options, the order of sent bits, the clock holds with their software release, and the returned data can only be shown by the bench's bus transactions, each checked against a queue of expected events.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int BYTE_W = 8;
    localparam int ADR_W  = 10;
    localparam int REG_W  = 16;

    localparam logic [1:0] SEL_CTL = 2'd0;
    localparam logic [1:0] SEL_ADR = 2'd1;
    localparam logic [1:0] SEL_RX  = 2'd2;

    localparam logic [4:0] TEN_TAG = 5'b11110;

    // bit 0 is on ... bit 5 is scl_free
    typedef struct packed {
        logic scl_free;
        logic hold_en;
        logic gc_en;
        logic take_all;
        logic wide_addr;
        logic on;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam ctl_t CTL_RST = '{scl_free: 1'b1, default: 1'b0};

    typedef enum logic [2:0] {ST_IDLE, ST_ADR1, ST_ADR2, ST_RX, ST_TX} phase_t;

    typedef struct packed {
        logic   ack;
        logic   hit;
        logic   set_hi;
        phase_t nxt;
    } verdict_t;

    function automatic logic is_ten_hdr(input logic [BYTE_W-1:0] b);
        return b[7:3] == TEN_TAG;
    endfunction
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
    import i2ct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             clr_tx,
    input  logic             clr_rx,
    output ctl_t             ctl,
    output logic [ADR_W-1:0] own_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= CTL_RST;
            own_addr <= '0;
        end else begin
            if (clr_tx || (clr_rx && ctl.hold_en))
                ctl.scl_free <= 1'b0;
            if (we && sel == SEL_CTL) begin
                ctl.on        <= wdata[0];
                ctl.wide_addr <= wdata[1];
                ctl.take_all  <= wdata[2];
                ctl.gc_en     <= wdata[3];
                ctl.hold_en   <= wdata[4];
                ctl.scl_free  <= ctl.hold_en ? wdata[5] : (ctl.scl_free | wdata[5]);
            end
            if (we && sel == SEL_ADR)
                own_addr <= wdata[ADR_W-1:0];
        end
    end

    // R10: without hold enable only a send start may lower the release bit
    a_r10_free_only_tx: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl.scl_free) && !$past(ctl.hold_en)) |-> $past(clr_tx));
endmodule

// File: rtl/i2ct_match.sv
module i2ct_match
    import i2ct_pkg::*;
(
    input  phase_t            ph,
    input  logic [BYTE_W-1:0] byte_in,
    input  ctl_t              ctl,
    input  logic [ADR_W-1:0]  own_addr,
    input  logic              hi_ok,
    output verdict_t          v
);
    logic seven_hit;
    logic hi_hit;

    assign seven_hit = ctl.take_all || (!ctl.wide_addr && byte_in[7:1] == own_addr[6:0]);
    assign hi_hit    = ctl.take_all || byte_in[2:1] == own_addr[9:8];

    always_comb begin
        v     = '0;
        v.nxt = ST_IDLE;
        case (ph)
            ST_ADR1: begin
                if (ctl.gc_en && byte_in == '0) begin
                    v.ack = 1'b1; v.hit = 1'b1; v.nxt = ST_RX;
                end else if (ctl.wide_addr && is_ten_hdr(byte_in) && hi_hit) begin
                    if (!byte_in[0]) begin
                        v.ack = 1'b1; v.nxt = ST_ADR2;
                    end else if (hi_ok || ctl.take_all) begin
                        v.ack = 1'b1; v.hit = 1'b1; v.nxt = ST_TX;
                    end
                end else if (seven_hit) begin
                    v.ack = 1'b1; v.hit = 1'b1;
                    v.nxt = byte_in[0] ? ST_TX : ST_RX;
                end
            end
            ST_ADR2: begin
                if (ctl.take_all || byte_in == own_addr[7:0]) begin
                    v.ack = 1'b1; v.hit = 1'b1; v.set_hi = 1'b1; v.nxt = ST_RX;
                end
            end
            default: v.nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              sda_oe,
    output logic              scl_oe,
    input  logic              reg_we,
    input  logic              reg_rd,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rw_flag,
    output logic              irq
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
    localparam logic [3:0] ACK_BIT  = 4'(BYTE_W);

    logic sda_s, scl_s, sda_d, scl_d;
    logic scl_rise, scl_fall, start_c, stop_c;
    ctl_t ctl;
    logic [ADR_W-1:0] own_addr;
    verdict_t v;

    phase_t st, nxt_st;
    logic [3:0] cnt;
    logic armed, ack_oe, m_ack, hi_ok;
    logic [BYTE_W-1:0] shreg, txbuf;
    logic fall_ev, ack_end, rx_done, go_tx, clr_tx, clr_rx, tx_oe;

    i2ct_sync #(.STAGES(SYNC_STAGES)) u_sda (.clk(clk), .rst(rst), .din(sda_in), .q(sda_s));
    i2ct_sync #(.STAGES(SYNC_STAGES)) u_scl (.clk(clk), .rst(rst), .din(scl_in), .q(scl_s));

    i2ct_ctrl u_ctrl (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .clr_tx(clr_tx), .clr_rx(clr_rx), .ctl(ctl), .own_addr(own_addr)
    );

    i2ct_match u_match (
        .ph(st), .byte_in(shreg), .ctl(ctl), .own_addr(own_addr), .hi_ok(hi_ok), .v(v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else begin
            sda_d <= sda_s;
            scl_d <= scl_s;
        end
    end

    assign scl_rise = scl_s && !scl_d;
    assign scl_fall = !scl_s && scl_d;
    assign start_c  = scl_s && scl_d && sda_d && !sda_s;
    assign stop_c   = scl_s && scl_d && !sda_d && sda_s;

    assign fall_ev = ctl.on && scl_fall && armed && st != ST_IDLE;
    assign ack_end = fall_ev && cnt == ACK_BIT;
    assign rx_done = fall_ev && cnt == LAST_BIT && st == ST_RX;
    assign go_tx   = ack_end && (st == ST_TX ? m_ack : nxt_st == ST_TX);
    assign clr_tx  = go_tx;
    assign clr_rx  = ack_end && st == ST_RX;

    // bit sequencing and address / data phases
    always_ff @(posedge clk) begin
        if (rst || !ctl.on) begin
            st <= ST_IDLE; nxt_st <= ST_IDLE; cnt <= '0; armed <= 1'b0;
            shreg <= '0; ack_oe <= 1'b0; m_ack <= 1'b0; hi_ok <= 1'b0;
            irq <= 1'b0; rw_flag <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start_c) begin
                st <= ST_ADR1; cnt <= '0; armed <= 1'b0; ack_oe <= 1'b0;
            end else if (stop_c) begin
                st <= ST_IDLE; armed <= 1'b0; ack_oe <= 1'b0; hi_ok <= 1'b0;
            end else if (st != ST_IDLE) begin
                if (scl_rise) begin
                    armed <= 1'b1;
                    if (cnt < ACK_BIT) shreg <= {shreg[BYTE_W-2:0], sda_s};
                    else               m_ack <= !sda_s;
                end else if (fall_ev) begin
                    armed <= 1'b0;
                    if (cnt == LAST_BIT) begin
                        cnt <= ACK_BIT;
                        case (st)
                            ST_ADR1, ST_ADR2: begin
                                ack_oe <= v.ack;
                                nxt_st <= v.ack ? v.nxt : ST_IDLE;
                                irq    <= v.hit;
                                if (v.hit)    rw_flag <= (v.nxt == ST_TX);
                                if (v.set_hi) hi_ok   <= 1'b1;
                                if (st == ST_ADR1 && !v.ack) hi_ok <= 1'b0;
                            end
                            ST_RX: begin
                                ack_oe <= 1'b1; nxt_st <= ST_RX; irq <= 1'b1;
                            end
                            default: nxt_st <= ST_TX;
                        endcase
                    end else if (cnt == ACK_BIT) begin
                        cnt    <= '0;
                        ack_oe <= 1'b0;
                        if (st == ST_TX) begin
                            st  <= m_ack ? ST_TX : ST_IDLE;
                            irq <= 1'b1;
                        end else begin
                            st <= nxt_st;
                        end
                    end else begin
                        cnt <= cnt + 4'd1;
                    end
                end
            end
        end
    end

    // received byte and its flag
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (rx_done) begin
            rx_data <= shreg;
            rx_full <= 1'b1;
        end else if (reg_rd && reg_sel == SEL_RX) begin
            rx_full <= 1'b0;
        end
    end

    // send byte follows tx_data only while the clock is held before bit 7
    always_ff @(posedge clk) begin
        if (rst) txbuf <= '0;
        else if (st == ST_TX && cnt == '0 && !ctl.scl_free && !scl_s) txbuf <= tx_data;
    end

    // clock hold starts only in a low phase
    always_ff @(posedge clk) begin
        if (rst) scl_oe <= 1'b0;
        else     scl_oe <= ctl.on && !ctl.scl_free && (!scl_s || scl_oe);
    end

    assign tx_oe  = st == ST_TX && cnt < ACK_BIT && !txbuf[3'(LAST_BIT) - cnt[2:0]];
    assign sda_oe = ctl.on && (ack_oe || tx_oe);

    always_comb begin
        case (reg_sel)
            SEL_CTL: reg_rdata = REG_W'(ctl);
            SEL_ADR: reg_rdata = REG_W'(own_addr);
            SEL_RX:  reg_rdata = REG_W'(rx_data);
            default: reg_rdata = '0;
        endcase
    end

    // R1: a disabled block leaves both lines alone
    a_r1_quiet_scl: assert property (@(posedge clk) disable iff (rst) !ctl.on |=> !scl_oe);
    a_r1_quiet_sda: assert property (@(posedge clk) disable iff (rst) !ctl.on |=> !sda_oe);
    // R6 / R7: interrupt is a single-cycle pulse
    a_r6_irq_single: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);
    // R7: direction flag set during a send
    a_r7_tx_dir: assert property (@(posedge clk) disable iff (rst) st == ST_TX |-> rw_flag);
    // R11: entering a send always finds the release bit cleared
    a_r11_tx_clear: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX && $past(st) != ST_TX && !$past(reg_we)) |-> !ctl.scl_free);
    // R9: SCL is pulled only after the release bit was low
    a_r9_hold_follows: assert property (@(posedge clk) disable iff (rst)
        scl_oe |-> !$past(ctl.scl_free));
    // R12: SDA drive moves only while SCL is low
    a_r12_sda_low_phase: assert property (@(posedge clk) disable iff (rst)
        (ctl.on && $past(ctl.on) && !$past(start_c) && !$past(stop_c) && sda_oe != $past(sda_oe))
        |-> !scl_s);
endmodule

// File: tb/i2c_tgt_stretch_test.sv
module i2c_tgt_stretch_test;
    localparam int HALF = 20;

    typedef struct {
        int         kind;   // 0 write address, 1 read address, 2 rx byte, 3 tx byte
        logic [7:0] data;
        string      tag;
    } ev_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_sda_lo = 1'b0, m_scl_lo = 1'b0;
    logic sda, scl, sda_oe, scl_oe;
    logic reg_we = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic [7:0] tx_data = '0, rx_data;
    logic rx_full, rw_flag, irq;

    int checks = 0;
    int errors = 0;
    ev_t exp_q[$];

    always #2.5 clk = ~clk;

    assign sda = !(m_sda_lo || sda_oe);
    assign scl = !(m_scl_lo || scl_oe);

    i2c_tgt_stretch uut (
        .clk(clk), .rst(rst), .sda_in(sda), .scl_in(scl), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .reg_we(reg_we), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_data(tx_data), .rx_data(rx_data), .rx_full(rx_full),
        .rw_flag(rw_flag), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int kind, input logic [7:0] data, input string tag);
        ev_t e;
        e.kind = kind; e.data = data; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic scl_up();
        int t = 0;
        m_scl_lo = 1'b0;
        while (!scl && t < 4000) begin cyc(1); t++; end
        if (!scl) check(1'b0, "R9", "SCL never released", 16'(scl), 16'd1);
    endtask

    task automatic bus_start();
        m_sda_lo = 1'b0; cyc(HALF);
        scl_up(); cyc(HALF);
        m_sda_lo = 1'b1; cyc(HALF);
        m_scl_lo = 1'b1; cyc(4);
    endtask

    task automatic bus_stop();
        m_sda_lo = 1'b1; cyc(HALF);
        scl_up(); cyc(HALF);
        m_sda_lo = 1'b0; cyc(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda_lo = !b[i]; cyc(HALF);
            scl_up(); cyc(HALF);
            m_scl_lo = 1'b1; cyc(4);
        end
        m_sda_lo = 1'b0; cyc(HALF);
        scl_up(); cyc(HALF / 2);
        acked = !sda; cyc(HALF / 2);
        m_scl_lo = 1'b1; cyc(4);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda_lo = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            cyc(HALF);
            scl_up(); cyc(HALF / 2);
            b[i] = sda; cyc(HALF / 2);
            m_scl_lo = 1'b1; cyc(4);
        end
        m_sda_lo = give_ack; cyc(HALF);
        scl_up(); cyc(HALF);
        m_scl_lo = 1'b1; cyc(4);
        m_sda_lo = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] d);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        cyc(1);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, input bit strobe, output logic [15:0] d);
        reg_sel = sel; reg_rd = strobe;
        #1 d = reg_rdata;
        cyc(1);
        reg_rd = 1'b0;
    endtask

    // stretch observer used beside a master transfer: checks the hold, then releases
    task automatic hold_then_release(input string req, input logic [15:0] ctl_word);
        logic [15:0] rd;
        cyc(HALF * 4);
        check(scl == 1'b0 && m_scl_lo == 1'b0, req, "SCL held by target", 16'(scl), 16'd0);
        reg_read(2'd0, 1'b0, rd);
        check(rd[5] == 1'b0, req, "release bit cleared", rd, rd & 16'hFFDF);
        reg_write(2'd0, ctl_word);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && irq) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected irq", 16'd1, 16'd0);
            end else begin
                ev_t e;
                e = exp_q.pop_front();
                case (e.kind)
                    0: check(rw_flag == 1'b0, e.tag, "write address direction", 16'(rw_flag), 16'd0);
                    1: check(rw_flag == 1'b1, e.tag, "read address direction", 16'(rw_flag), 16'd1);
                    2: check(rx_data == e.data && rx_full, e.tag, "received byte",
                             {7'd0, rx_full, rx_data}, {8'd1, e.data});
                    default: check(rw_flag == 1'b1, e.tag, "sent byte event", 16'(rw_flag), 16'd1);
                endcase
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 16'd0, 16'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        logic [15:0] rd;

        cyc(6);
        rst = 1'b0;
        cyc(4);

        // R8 reset state
        reg_read(2'd0, 1'b0, rd);
        check(rd == 16'h0020, "R8", "control after reset", rd, 16'h0020);
        reg_read(2'd1, 1'b0, rd);
        check(rd == 16'h0000, "R8", "address after reset", rd, 16'h0000);
        check(!sda_oe && !scl_oe, "R8", "no drive after reset", {sda_oe, scl_oe}, 16'd0);

        // R1 disabled block ignores its own address
        reg_write(2'd1, 16'h003A);
        bus_start(); send_byte(8'h74, ack); bus_stop();
        check(!ack, "R1", "disabled block acknowledges", 16'(ack), 16'd0);

        // R2 / R6 matched write with data
        reg_write(2'd0, 16'h0021);
        bus_start();
        push(0, 8'h00, "R2");
        send_byte(8'h74, ack);
        check(ack, "R2", "7-bit address ack", 16'(ack), 16'd1);
        push(2, 8'hA5, "R6");
        send_byte(8'hA5, ack);
        check(ack, "R6", "data byte ack", 16'(ack), 16'd1);
        bus_stop();
        reg_read(2'd2, 1'b1, rd);
        check(rd == 16'h00A5, "R6", "rx register", rd, 16'h00A5);
        cyc(1);
        check(!rx_full, "R6", "rx_full after read", 16'(rx_full), 16'd0);

        // R2 mismatch
        bus_start(); send_byte(8'h76, ack); bus_stop();
        check(!ack, "R2", "wrong address ack", 16'(ack), 16'd0);

        // R7 / R11 send two bytes, each held until released
        tx_data = 8'hC3;
        bus_start();
        push(1, 8'h00, "R7");
        send_byte(8'h75, ack);
        check(ack, "R7", "read address ack", 16'(ack), 16'd1);
        push(3, 8'h00, "R7");
        fork
            recv_byte(1'b1, b);
            hold_then_release("R11", 16'h0021);
        join
        check(b == 8'hC3, "R7", "first sent byte", 16'(b), 16'h00C3);
        tx_data = 8'h5A;
        push(3, 8'h00, "R7");
        fork
            recv_byte(1'b0, b);
            hold_then_release("R11", 16'h0021);
        join
        check(b == 8'h5A, "R7", "second sent byte", 16'(b), 16'h005A);
        bus_stop();

        // R10 write of 0 ignored without hold enable, no receive stretch
        reg_write(2'd0, 16'h0001);
        reg_read(2'd0, 1'b0, rd);
        check(rd == 16'h0021, "R10", "release bit kept", rd, 16'h0021);
        bus_start();
        push(0, 8'h00, "R10");
        send_byte(8'h74, ack);
        push(2, 8'h11, "R10");
        send_byte(8'h11, ack);
        cyc(HALF);
        check(!scl_oe, "R10", "no stretch after receive", 16'(scl_oe), 16'd0);
        bus_stop();

        // R11 receive stretch with hold enable
        reg_write(2'd0, 16'h0031);
        bus_start();
        push(0, 8'h00, "R11");
        send_byte(8'h74, ack);
        push(2, 8'h3C, "R11");
        send_byte(8'h3C, ack);
        check(ack, "R11", "held byte acked", 16'(ack), 16'd1);
        fork
            bus_stop();
            hold_then_release("R11", 16'h0031);
        join

        // R9 software-forced hold
        reg_write(2'd0, 16'h0011);
        reg_read(2'd0, 1'b0, rd);
        check(rd == 16'h0011, "R9", "release written to 0", rd, 16'h0011);
        bus_start();
        fork
            bus_stop();
            begin
                cyc(HALF * 4);
                check(scl == 1'b0, "R9", "SCL forced low", 16'(scl), 16'd0);
                reg_write(2'd0, 16'h0031);
                cyc(HALF);
                check(scl == 1'b1, "R9", "SCL free after write 1", 16'(scl), 16'd1);
            end
        join

        // R3 10-bit write then repeated START read
        reg_write(2'd0, 16'h0021);
        reg_write(2'd0, 16'h0023);
        reg_write(2'd1, 16'h02C5);
        bus_start();
        send_byte(8'hF4, ack);
        check(ack, "R3", "10-bit header ack", 16'(ack), 16'd1);
        push(0, 8'h00, "R3");
        send_byte(8'hC5, ack);
        check(ack, "R3", "10-bit low byte ack", 16'(ack), 16'd1);
        push(2, 8'h99, "R3");
        send_byte(8'h99, ack);
        tx_data = 8'h6E;
        bus_start();
        push(1, 8'h00, "R3");
        send_byte(8'hF5, ack);
        check(ack, "R3", "10-bit read header ack", 16'(ack), 16'd1);
        push(3, 8'h00, "R3");
        fork
            recv_byte(1'b0, b);
            hold_then_release("R11", 16'h0023);
        join
        check(b == 8'h6E, "R3", "10-bit sent byte", 16'(b), 16'h006E);
        bus_stop();
        bus_start();
        send_byte(8'hF4, ack);
        send_byte(8'hC4, ack);
        check(!ack, "R3", "wrong 10-bit low byte", 16'(ack), 16'd0);
        bus_stop();

        // R4 take-all
        reg_write(2'd0, 16'h0025);
        bus_start();
        push(0, 8'h00, "R4");
        send_byte(8'hAA, ack);
        check(ack, "R4", "any address ack", 16'(ack), 16'd1);
        bus_stop();

        // R5 general call
        reg_write(2'd0, 16'h0021);
        bus_start(); send_byte(8'h00, ack); bus_stop();
        check(!ack, "R5", "general call disabled", 16'(ack), 16'd0);
        reg_write(2'd0, 16'h0029);
        bus_start();
        push(0, 8'h00, "R5");
        send_byte(8'h00, ack);
        check(ack, "R5", "general call enabled", 16'(ack), 16'd1);
        bus_stop();

        cyc(20);
        check(exp_q.size() == 0, "R6", "missing irq events", 16'(exp_q.size()), 16'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule